// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block gathers service requests from a small group of DMA channels and nominates one channel at a time to a transfer engine. A channel asks for service in one of two ways. A peripheral can raise its request line, which counts only while that channel's enable bit is set. Software can also set the channel's start flag, which counts whatever the enable bit says. The engine receives a registered grant made of a valid flag and a channel index. It returns a one-cycle done pulse when it has finished with that channel.

A small register port holds the settings. These are a mode bit that selects fixed-priority or round-robin selection, a priority field for each channel, the enable mask, and the start flags. Two single-byte command registers set or clear one channel's enable bit without a read-modify-write. Each command carries a skip bit that turns the write into a no-op. The mode can be changed while the block runs, and the change applies to the next selection.

Top module: `dma_req_arbiter`

## Requirements
- R1: In fixed-priority mode (control register at address 0, bit 0 = 0) the eligible channel with the largest priority value is granted. The priority of channel n is at address 16+n, in the low PRIO_W bits.
- R2: In fixed-priority mode, when eligible channels share the largest priority value, the channel with the higher index wins.
- R3: In round-robin mode (address 0, bit 0 = 1) the search begins at the channel after the last granted one and wraps from NUM_CH-1 to 0. After reset the search begins at channel 0.
- R4: The mode bit can be rewritten at any time, and the next grant follows the new mode.
- R5: A hardware request counts only while that channel's bit in the enable mask is set. The mask is at address 1 and can be read and written as a whole.
- R6: Writing ones to the start register (address 4) sets the matching start flags. A start flag requests its channel regardless of the enable mask. The flag is cleared when that channel is granted. Reading address 4 returns the pending flags.
- R7: A write to address 2 with bit 7 clear sets the enable bit of the channel numbered in bits 6:0. No other mask bit changes.
- R8: A write to address 3 with bit 7 clear clears the enable bit of the channel numbered in bits 6:0. No other mask bit changes.
- R9: A write to address 2 or 3 with bit 7 set leaves the mask unchanged.
- R10: grant_valid and grant_ch stay constant until eng_done. After done, grant_valid is low for at least one cycle before the next grant.
- R11: After reset the enable mask, the start flags and the mode bit are zero, which selects fixed priority, and grant_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | NUM_CH | Peripheral request lines, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| grant_valid | output | 1 | A channel is granted to the engine |
| grant_ch | output | CH_W | Index of the granted channel |
| eng_done | input | 1 | Engine has finished with the granted channel |

## Verification
A wrong enable mask or a lost start flag appears at the ports as a grant that should not happen, or a missing one, on the second clock edge after the request settles. A mask fault also shows on readback at address 1 in the same cycle. A stale round-robin pointer or a bad priority comparison shows up on the next grant as a wrong channel index, so the bench runs chains of back-to-back grants and compares each index in order. A fault in the handshake shows as the index moving while it should hold, or as grant_valid failing to drop for one cycle after done.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;

    localparam int ADDR_CTRL      = 0;
    localparam int ADDR_MASK      = 1;
    localparam int ADDR_SET_EN    = 2;
    localparam int ADDR_CLR_EN    = 3;
    localparam int ADDR_START     = 4;
    localparam int ADDR_PRIO_BASE = 16;

    typedef struct packed {
        logic       skip;
        logic [6:0] chan;
    } en_cmd_t;

    function automatic en_cmd_t decode_cmd(input logic [7:0] b);
        en_cmd_t c;
        c.skip = b[7];
        c.chan = b[6:0];
        return c;
    endfunction

endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 2,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     grant_fire,
    input  logic [CH_W-1:0]          grant_idx,
    output arb_mode_e                mode,
    output logic [NUM_CH-1:0]        en_mask,
    output logic [NUM_CH-1:0]        start_pend,
    output logic [NUM_CH*PRIO_W-1:0] prio_flat
);

    logic [PRIO_W-1:0] prio_q [NUM_CH];
    en_cmd_t           cmd;
    logic [NUM_CH-1:0] cmd_bit;
    logic [NUM_CH-1:0] mask_nxt;
    logic [NUM_CH-1:0] start_nxt;

    assign cmd = decode_cmd(wdata[7:0]);

    always_comb begin
        cmd_bit = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cmd.chan == 7'(i)) cmd_bit[i] = 1'b1;
        end
    end

    always_comb begin
        mask_nxt = en_mask;
        if (we) begin
            if (addr == ADDR_W'(ADDR_MASK))
                mask_nxt = wdata[NUM_CH-1:0];
            else if (addr == ADDR_W'(ADDR_SET_EN) && !cmd.skip)
                mask_nxt = en_mask | cmd_bit;
            else if (addr == ADDR_W'(ADDR_CLR_EN) && !cmd.skip)
                mask_nxt = en_mask & ~cmd_bit;
        end
    end

    always_comb begin
        start_nxt = start_pend;
        if (grant_fire) start_nxt[grant_idx] = 1'b0;
        if (we && addr == ADDR_W'(ADDR_START))
            start_nxt = start_nxt | wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= ARB_FIXED;
            en_mask    <= '0;
            start_pend <= '0;
        end else begin
            if (we && addr == ADDR_W'(ADDR_CTRL))
                mode <= arb_mode_e'(wdata[0]);
            en_mask    <= mask_nxt;
            start_pend <= start_nxt;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= '0;
            else if (we && addr == ADDR_W'(ADDR_PRIO_BASE + g))
                prio_q[g] <= wdata[PRIO_W-1:0];
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL))
            rdata[0] = mode;
        else if (addr == ADDR_W'(ADDR_MASK))
            rdata[NUM_CH-1:0] = en_mask;
        else if (addr == ADDR_W'(ADDR_START))
            rdata[NUM_CH-1:0] = start_pend;
        else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(ADDR_PRIO_BASE + i))
                    rdata[PRIO_W-1:0] = prio_q[i];
            end
        end
    end

endmodule

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 2,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     any,
    output logic [CH_W-1:0]          pick
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        pick = '0;
        best = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] >= best)) begin
                any  = 1'b1;
                best = prio_flat[i*PRIO_W +: PRIO_W];
                pick = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [CH_W-1:0]   last,
    output logic              any,
    output logic [CH_W-1:0]   pick
);

    logic [CH_W:0]   sum;
    logic [CH_W-1:0] cand;

    always_comb begin
        any  = 1'b0;
        pick = '0;
        sum  = '0;
        cand = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            sum = {1'b0, last} + (CH_W+1)'(k);
            if (sum >= (CH_W+1)'(NUM_CH)) sum = sum - (CH_W+1)'(NUM_CH);
            cand = sum[CH_W-1:0];
            if (!any && req[cand]) begin
                any  = 1'b1;
                pick = cand;
            end
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 2,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              grant_valid,
    output logic [CH_W-1:0]   grant_ch,
    input  logic              eng_done
);

    arb_mode_e                mode;
    logic [NUM_CH-1:0]        en_mask;
    logic [NUM_CH-1:0]        start_pend;
    logic [NUM_CH*PRIO_W-1:0] prio_flat;
    logic [NUM_CH-1:0]        eligible;
    logic                     fx_any, rr_any, sel_any;
    logic [CH_W-1:0]          fx_pick, rr_pick, sel_pick;
    logic [CH_W-1:0]          last_ch;
    logic                     fire;

    dma_arb_regs #(
        .NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .grant_fire(fire), .grant_idx(sel_pick),
        .mode(mode), .en_mask(en_mask), .start_pend(start_pend),
        .prio_flat(prio_flat)
    );

    assign eligible = (hw_req & en_mask) | start_pend;

    dma_arb_fixed_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) fixed_i (
        .req(eligible), .prio_flat(prio_flat), .any(fx_any), .pick(fx_pick)
    );

    dma_arb_rr_pick #(.NUM_CH(NUM_CH)) rr_i (
        .req(eligible), .last(last_ch), .any(rr_any), .pick(rr_pick)
    );

    always_comb begin
        if (mode == ARB_ROUND) begin
            sel_any  = rr_any;
            sel_pick = rr_pick;
        end else begin
            sel_any  = fx_any;
            sel_pick = fx_pick;
        end
    end

    assign fire = !grant_valid && sel_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_ch    <= '0;
            last_ch     <= CH_W'(NUM_CH - 1);
        end else if (fire) begin
            grant_valid <= 1'b1;
            grant_ch    <= sel_pick;
            last_ch     <= sel_pick;
        end else if (grant_valid && eng_done) begin
            grant_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] hw_req,
    input logic [NUM_CH-1:0] en_mask,
    input logic [NUM_CH-1:0] start_pend,
    input logic              reg_we,
    input logic              grant_valid,
    input logic [CH_W-1:0]   grant_ch,
    input logic              eng_done
);

    logic [NUM_CH-1:0] req_q;
    logic              rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) req_q <= '0;
        else     req_q <= (hw_req & en_mask) | start_pend;
    end

    a_r10_hold_until_done: assert property (@(posedge clk) disable iff (rst)
        grant_valid && !eng_done |=> grant_valid && $stable(grant_ch));

    a_r10_gap_after_done: assert property (@(posedge clk) disable iff (rst)
        grant_valid && eng_done |=> !grant_valid);

    a_r5_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> req_q[grant_ch]);

    a_r7_mask_needs_write: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(en_mask));

    a_r6_start_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) && !$past(reg_we) |-> !start_pend[grant_ch]);

    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            a_r11_reset_state: assert (en_mask == '0 && start_pend == '0 && !grant_valid);
        end
    end

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
    .clk(clk), .rst(rst), .hw_req(hw_req), .en_mask(en_mask),
    .start_pend(start_pend), .reg_we(reg_we), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .eng_done(eng_done)
);

// File: tb/dma_req_arbiter_tb_top.sv
module dma_req_arbiter_tb_top;

    localparam int NUM_CH = 4;
    localparam int PRIO_W = 2;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] hw_req = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              grant_valid;
    logic [CH_W-1:0]   grant_ch;
    logic              eng_done = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit ended = 1'b0;
    int exp_q[$];
    logic gv_prev = 1'b0;

    always #5 clk = ~clk;

    dma_req_arbiter #(
        .NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) dut_i (
        .clk(clk), .rst(rst), .hw_req(hw_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grant_valid(grant_valid), .grant_ch(grant_ch), .eng_done(eng_done)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic check(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Monitor: compare each new grant with the next expected channel.
    always @(negedge clk) begin
        if (!rst && grant_valid && !gv_prev) begin
            if (exp_q.size() == 0) begin
                check("grant without expectation", int'(grant_ch), -1);
            end else begin
                check("R1/R2/R3/R6 granted channel", int'(grant_ch), exp_q.pop_front());
            end
        end
        gv_prev = grant_valid;
    end

    task automatic reg_write(input int a, input int d);
        reg_addr  = ADDR_W'(a);
        reg_wdata = DATA_W'(d);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_check(input string req, input int a, input int expected);
        reg_addr = ADDR_W'(a);
        #1;
        check(req, int'(reg_rdata), expected);
    endtask

    task automatic serve(input int ch, input logic [NUM_CH-1:0] next_req);
        for (int i = 0; i < 50 && !grant_valid; i++) @(negedge clk);
        if (!grant_valid) begin
            check("R10 grant timeout", 0, 1);
            return;
        end
        repeat (3) @(negedge clk);
        check("R10 grant held", int'(grant_valid), 1);
        check("R10 index held", int'(grant_ch), ch);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        check("R10 gap after done", int'(grant_valid), 0);
        hw_req = next_req;
    endtask

    task automatic step(input int ch, input logic [NUM_CH-1:0] next_req);
        exp_q.push_back(ch);
        serve(ch, next_req);
    endtask

    task automatic expect_idle(input string req);
        repeat (5) @(negedge clk);
        check(req, int'(grant_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 grant_valid", int'(grant_valid), 0);
        reg_check("R11 mode", 0, 0);
        reg_check("R11 mask", 1, 0);
        reg_check("R11 start", 4, 0);

        // R5: requests with a zero mask are ignored
        hw_req = 4'b1111;
        expect_idle("R5 masked requests");
        hw_req = 4'b0000;

        // R7 / R8 / R9 command registers
        reg_write(2, 1);
        reg_check("R7 set ch1", 1, 4'b0010);
        reg_write(2, 8'h82);
        reg_check("R9 skip on set", 1, 4'b0010);
        reg_write(2, 0);
        reg_write(2, 2);
        reg_write(2, 3);
        reg_check("R7 set rest", 1, 4'b1111);
        reg_write(3, 2);
        reg_check("R8 clear ch2", 1, 4'b1011);
        reg_write(3, 8'h80);
        reg_check("R9 skip on clear", 1, 4'b1011);
        reg_write(2, 2);
        reg_check("R7 set ch2 again", 1, 4'b1111);

        // priorities: ch0=3 ch1=1 ch2=3 ch3=0
        reg_write(16, 3);
        reg_write(17, 1);
        reg_write(18, 3);
        reg_write(19, 0);
        reg_check("R1 prio readback", 18, 3);

        // R1 / R2 fixed priority
        exp_q.push_back(2);               // R2 tie 0 vs 2 goes to 2
        hw_req = 4'b1111;
        serve(2, 4'b1111);
        step(2, 4'b0011);                 // R1 fixed keeps choosing ch2
        step(0, 4'b1010);                 // R1 ch0 prio 3 over ch1
        step(1, 4'b0000);                 // R1 ch1 prio 1 over ch3 prio 0

        // R5 cleared enable blocks the hardware line
        reg_write(3, 2);
        hw_req = 4'b0100;
        expect_idle("R5 disabled channel");

        // R6 software start overrides the mask, flag clears on grant
        exp_q.push_back(2);
        reg_write(4, 4'b0100);
        for (int i = 0; i < 10 && !grant_valid; i++) @(negedge clk);
        reg_check("R6 start cleared", 4, 0);
        serve(2, 4'b0000);

        // R4 switch to round robin, R3 rotation and wrap
        reg_write(0, 1);
        reg_check("R4 mode readback", 0, 1);
        reg_write(1, 4'b1111);
        reg_check("R5 mask write", 1, 4'b1111);
        exp_q.push_back(3);
        hw_req = 4'b1111;
        serve(3, 4'b1111);                // R3 after last grant ch2
        step(0, 4'b1111);                 // R3 wrap
        step(1, 4'b1111);
        step(2, 4'b1111);
        step(3, 4'b0101);
        step(0, 4'b0101);                 // R3 skip idle channels
        step(2, 4'b0101);
        step(0, 4'b0000);                 // R3 wrap past ch3

        // R4 back to fixed priority at runtime
        reg_write(0, 0);
        exp_q.push_back(2);
        hw_req = 4'b1111;
        serve(2, 4'b0000);

        expect_idle("R10 idle after last done");
        check("R1 expectation queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule